// File: doc/BRIEF.md
# Performance Monitor Cycle Counter

This block is the 64-bit clock-cycle counter of a performance monitoring unit. While its enable input is high it advances by one, either on every clock or, with the divide option selected, on every 64th enabled clock. A small prescaler inside the block counts the enabled clocks.

Software can load the counter through a write port. A clear strobe zeroes both the counter and the prescaler.

An overflow is a transition of the selected bit from 1 to 0 when the counter increments. A mode input picks that bit: bit 31 for a short counter or bit 63 for a long one. The block reports an overflow as a one-cycle pulse. The overflow status logic uses that pulse to set its cycle-counter flag, which is bit 31 of its status word.

Top module: `pmu_cycle_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `ovf_set` is 0. The prescaler is also cleared.
- R2: When `cnt_en` is 1 and `div64` is 0, `count` rises by exactly one on each clock edge.
- R3: When `cnt_en` is 0, `count` and the prescaler hold their values, unless a write or a clear is applied.
- R4: When `div64` is 1, `count` rises by one only on the 64th enabled clock counted since the prescaler was last zero. Clocks with `cnt_en` at 0 do not advance the prescaler.
- R5: A clear (`clr` = 1) sets `count` and the prescaler to 0 at the next edge. It takes priority over a write and over an increment, and it never raises `ovf_set`.
- R6: A write (`wr_en` = 1) loads `wr_data` into `count` at the next edge. The write takes priority over an increment in the same cycle, and the write itself never raises `ovf_set`. The prescaler keeps advancing during a write.
- R7: When `long_mode` is 0, an increment that takes bit 31 of `count` from 1 to 0 raises `ovf_set`. In this mode the carry still propagates into bits 63:32.
- R8: When `long_mode` is 1, only an increment that takes bit 63 from 1 to 0 raises `ovf_set`. A carry out of bit 31 in this mode raises nothing.
- R9: `ovf_set` is high for exactly one cycle. That cycle is the one in which the wrapped value first appears on `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting enable |
| div64 | input | 1 | 1: advance once every 64 enabled clocks |
| long_mode | input | 1 | 1: overflow at bit 63, 0: overflow at bit 31 |
| clr | input | 1 | Clear strobe for the counter and the prescaler |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Value loaded by a write |
| count | output | 64 | Current counter value |
| ovf_set | output | 1 | One-cycle overflow pulse to the status logic |

## Verification
A software write can land in the same cycle as an increment that would wrap the selected overflow bit. The bench provokes this by loading 0xFFFF_FFFF in short mode and then writing a new value while counting is still enabled. It passes only if the written value appears and `ovf_set` stays low.

A clear can also coincide with a write. The bench drives both strobes in one cycle and expects `count` to read zero. It then expects a full 64-clock wait before the next divided increment, which shows that the clear also zeroed the prescaler.

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int WIDTH     = 64,
  parameter int SHORT_BIT = 31,
  parameter int PRESCALE  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             div64,
  input  logic             long_mode,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] count,
  output logic             ovf_set
);
  localparam int PW = $clog2(PRESCALE);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0]    pre_q;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_inc;
  logic             ovf_q;
  logic             tick;
  logic             wrap;

  assign tick    = cnt_en && (!div64 || pre_q == PRE_LAST);
  assign cnt_inc = cnt_q + WIDTH'(1);
  assign wrap    = long_mode ? (cnt_q[WIDTH-1] & ~cnt_inc[WIDTH-1])
                             : (cnt_q[SHORT_BIT] & ~cnt_inc[SHORT_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr) begin
      pre_q <= '0;
    end else if (cnt_en && div64) begin
      pre_q <= pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (clr) begin
        cnt_q <= '0;
      end else if (wr_en) begin
        cnt_q <= wr_data;
      end else if (tick) begin
        cnt_q <= cnt_inc;
        ovf_q <= wrap;
      end
    end
  end

  assign count   = cnt_q;
  assign ovf_set = ovf_q;
endmodule

// File: rtl/pmu_cycle_counter_chk.sv
module pmu_cycle_counter_chk #(
  parameter int WIDTH     = 64,
  parameter int SHORT_BIT = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             div64,
  input logic             long_mode,
  input logic             clr,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] count,
  input logic             ovf_set
);
  AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !div64 && !clr && !wr_en) |=> (count == $past(count) + WIDTH'(1))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !clr && !wr_en) |=> ($stable(count) && !ovf_set)); // R3
  AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && div64 && !clr && !wr_en) |=>
      (count == $past(count) || count == $past(count) + WIDTH'(1))); // R4
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !ovf_set)); // R5
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (count == $past(wr_data) && !ovf_set)); // R6
  AST_SHORT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && !$past(long_mode)) |-> ($past(count[SHORT_BIT]) && !count[SHORT_BIT])); // R7
  AST_LONG_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_set && $past(long_mode)) |-> ($past(count[WIDTH-1]) && !count[WIDTH-1])); // R8
  AST_PULSE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |-> (count == $past(count) + WIDTH'(1))); // R9
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> !ovf_set); // R9
endmodule

bind pmu_cycle_counter pmu_cycle_counter_chk #(.WIDTH(WIDTH), .SHORT_BIT(SHORT_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .div64(div64), .long_mode(long_mode),
  .clr(clr), .wr_en(wr_en), .wr_data(wr_data), .count(count), .ovf_set(ovf_set)
);

// File: tb/pmu_cycle_counter_bench.sv
`timescale 1ns/1ps
module pmu_cycle_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, div64 = 1'b0, long_mode = 1'b0, clr = 1'b0, wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [63:0] count;
  logic        ovf_set;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [63:0] q_cnt[$];
  logic        q_ovf[$];
  string       q_tag[$];

  logic [63:0] m_cnt = '0;
  logic [5:0]  m_pre = '0;

  always #2 clk = ~clk;

  pmu_cycle_counter u_pmu_cycle_counter (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .div64(div64), .long_mode(long_mode),
    .clr(clr), .wr_en(wr_en), .wr_data(wr_data), .count(count), .ovf_set(ovf_set)
  );

  task automatic step(input logic en, input logic dv, input logic lg, input logic cl,
                      input logic wr, input logic [63:0] wd, input string tag);
    logic        tick;
    logic        e_ovf;
    logic [63:0] nxt;
    @(negedge clk);
    cnt_en = en; div64 = dv; long_mode = lg; clr = cl; wr_en = wr; wr_data = wd;
    e_ovf = 1'b0;
    if (cl) begin
      m_cnt = '0;
      m_pre = '0;
    end else begin
      tick = en && (!dv || m_pre == 6'd63);
      if (en && dv) m_pre = m_pre + 6'd1;
      if (wr) begin
        m_cnt = wd;
      end else if (tick) begin
        nxt   = m_cnt + 64'd1;
        e_ovf = lg ? (m_cnt[63] && !nxt[63]) : (m_cnt[31] && !nxt[31]);
        m_cnt = nxt;
      end
    end
    q_cnt.push_back(m_cnt);
    q_ovf.push_back(e_ovf);
    q_tag.push_back(tag);
  endtask

  initial begin : monitor
    logic [63:0] ec;
    logic        eo;
    string       t;
    forever begin
      @(posedge clk);
      #1;
      if (q_cnt.size() > 0) begin
        ec = q_cnt.pop_front();
        eo = q_ovf.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (count !== ec || ovf_set !== eo) begin
          failures++;
          $display("FAIL %s count=%h ovf=%b expected count=%h ovf=%b", t, count, ovf_set, ec, eo);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (count !== 64'd0 || ovf_set !== 1'b0) begin
      failures++;
      $display("FAIL R1 count=%h ovf=%b expected count=0 ovf=0", count, ovf_set);
    end
    rst_n = 1'b1;

    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0, '0, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, '0, "R3");

    step(0, 0, 0, 0, 1, 64'h0000_0005_FFFF_FFFD, "R6");
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, '0, "R7_R9");

    step(0, 0, 1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFE, "R6");
    for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 0, '0, "R8_R9");
    step(0, 0, 1, 0, 1, 64'h0000_0000_FFFF_FFFF, "R6");
    step(1, 0, 1, 0, 0, '0, "R8");

    step(0, 0, 0, 0, 1, 64'h0000_0000_FFFF_FFFF, "R6");
    step(1, 0, 0, 0, 1, 64'h0000_0000_0000_1234, "R6");
    step(0, 0, 0, 0, 1, 64'h0000_0000_0000_0000, "R6");

    step(0, 0, 0, 0, 1, 64'h0000_0000_0000_0077, "R6");
    step(1, 0, 0, 1, 1, 64'h0000_0000_0000_0099, "R5");

    for (int i = 0; i < 40; i++) step(1, 1, 0, 0, 0, '0, "R4");
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 0, '0, "R3_R4");
    for (int i = 0; i < 30; i++) step(1, 1, 0, 0, 0, '0, "R4");

    for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 0, '0, "R4");
    step(0, 1, 0, 1, 0, '0, "R5");
    for (int i = 0; i < 65; i++) step(1, 1, 0, 0, 0, '0, "R5_R4");

    step(0, 1, 0, 0, 1, 64'h0000_0000_FFFF_FFFF, "R6");
    for (int i = 0; i < 64; i++) step(1, 1, 0, 0, 0, '0, "R7_R4");
    step(0, 0, 0, 0, 0, '0, "R9");

    while (q_cnt.size() > 0) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule